// File: doc/BRIEF.md
# Seeded Inverted CRC-8 Generator

This block computes the 8-bit check value that closes a synchronous serial sensor transfer. A transfer is a command word followed by any number of 16-bit data words, sent by either side. The block takes those words through a valid/ready stream input and folds them into an 8-bit shift register that starts at all ones. Each word is processed most significant bit first, and the words are taken in the order they appear on the bus. When the transfer ends, the block presents the bitwise complement of the register. That byte becomes the low byte of the trailing safety word. The upper byte of the safety word is never fed to the block.

A build-time parameter selects the engine. The word engine folds a whole word into the register in one clock and never drops `wd_ready_o`. The bit engine applies one bit per clock, so it takes 16 clocks per word, and it lowers `wd_ready_o` while it shifts. A word moves only in a cycle where `wd_valid_i` and `wd_ready_o` are both high. The sender may hold `wd_valid_i` and `wd_data_i` for as long as ready stays low, and nothing is lost. `xfer_start_i` and `xfer_end_i` are single-cycle control pulses and take no handshake. An end request that arrives while the bit engine is still shifting is held and served when the last bit has been applied. `wd_ready_o` stays low while that request is held.

Top module: `crc8_seed_inv`

## Requirements
- R1: The register uses the polynomial x^8+x^4+x^3+x^2+1 (feedback mask 8'h1D). Each word is applied MSB first (bit 15 down to bit 0), and the register starts at 8'hFF. The value presented is the bitwise complement of the final register. The command 16'h5081 followed by the data 16'h0804 gives 8'h89.
- R2: A start pulse discards all state, including a word that the bit engine is partly through, and reseeds the register to 8'hFF. A word accepted in the same cycle as the start pulse is the first word of the new transfer.
- R3: In word mode `wd_ready_o` stays high. Every accepted word is folded in during its own clock. `crc_done_o` is high in the cycle that follows the cycle in which `xfer_end_i` was sampled.
- R4: In bit mode `wd_ready_o` goes low for exactly 15 cycles after a word is accepted. The result equals the word-mode result for the same words.
- R5: In bit mode an end request sampled while a word is still shifting is deferred. `crc_done_o` rises in the cycle after the final bit step, which is 15 cycles after the last word was accepted, and `crc_o` then includes that whole word.
- R6: `crc_done_o` is a one-cycle pulse for each end request. Between a done pulse and the next start pulse, `crc_o` holds its value, even if further words are accepted without an end request.
- R7: A start pulse sets `crc_o` to 8'h00 in the next cycle. When start and end are sampled in the same cycle, start wins and no done pulse follows.
- R8: An end request with no words since the start pulse gives `crc_o` = 8'h00, which is the complement of the seed.
- R9: After reset `crc_o` is 8'h00, `crc_done_o` is low and `wd_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_start_i | input | 1 | Start-of-transfer pulse; reseeds the register |
| wd_valid_i | input | 1 | A word is offered on `wd_data_i` |
| wd_ready_o | output | 1 | The block can take a word this cycle |
| wd_data_i | input | 16 | Word to fold in, MSB first |
| xfer_end_i | input | 1 | End-of-transfer request |
| crc_o | output | 8 | Inverted remainder, held until the next start |
| crc_done_o | output | 1 | One-cycle pulse when `crc_o` takes a new result |

## Verification
Both engines are given the fixed pair 16'h5081, 16'h0804. Because the expected value is a constant rather than a model output, this pair catches a wrong seed, polynomial, bit order or final inversion.

Empty transfers isolate the seed and the inversion from the per-word update. Random sequences of one to six words, compared against a bit-by-bit model, expose any difference between the unrolled update and sixteen single steps.

Directed cases cover a start pulse that interrupts the bit engine part-way through a word, and a start pulse that carries the first word. They also cover start and end arriving together, and an end request issued while shifting. Together these separate correct reseeding, deferral and priority from off-by-one timing in the done pulse and the ready window.

// File: rtl/crc8si_pkg.sv
package crc8si_pkg;
  typedef enum logic {
    FEED_WORD = 1'b0,
    FEED_BIT  = 1'b1
  } feed_mode_e;
endpackage

// File: rtl/crc8si_unroll.sv
// STEPS back-to-back LFSR shifts; d_in is consumed MSB first.
module crc8si_unroll #(
  parameter int unsigned       W     = 8,
  parameter int unsigned       STEPS = 16,
  parameter logic [W-1:0]      POLY  = 8'h1D
) (
  input  logic [W-1:0]     c_in,
  input  logic [STEPS-1:0] d_in,
  output logic [W-1:0]     c_out
);
  logic [W-1:0] st [0:STEPS];

  assign st[0] = c_in;

  for (genvar i = 0; i < STEPS; i++) begin : g_step
    logic fb;
    assign fb        = st[i][W-1] ^ d_in[STEPS-1-i];
    assign st[i+1]   = {st[i][W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign c_out = st[STEPS];
endmodule

// File: rtl/crc8si_feed.sv
// Owns the running register; word engine or bit engine chosen by MODE.
module crc8si_feed
  import crc8si_pkg::*;
#(
  parameter feed_mode_e        MODE = FEED_WORD,
  parameter int unsigned       W    = 8,
  parameter int unsigned       DW   = 16,
  parameter logic [W-1:0]      POLY = 8'h1D,
  parameter logic [W-1:0]      SEED = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          acc_i,
  input  logic [DW-1:0] data_i,
  output logic [W-1:0]  crc_nxt_o,
  output logic          busy_q_o,
  output logic          busy_nxt_o
);
  localparam int unsigned CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 2);

  logic [W-1:0] crc_q;
  logic [W-1:0] base;

  assign base = start_i ? SEED : crc_q;

  if (MODE == FEED_WORD) begin : g_word
    logic [W-1:0] upd;

    crc8si_unroll #(.W(W), .STEPS(DW), .POLY(POLY)) u_unroll (
      .c_in (base),
      .d_in (data_i),
      .c_out(upd)
    );

    assign crc_nxt_o  = acc_i ? upd : base;
    assign busy_q_o   = 1'b0;
    assign busy_nxt_o = 1'b0;
  end else begin : g_bit
    logic [DW-1:0] sh_q, sh_nxt;
    logic [CW-1:0] cnt_q, cnt_nxt;
    logic          bsy_q, bsy_nxt;
    logic [W-1:0]  cin, upd;
    logic          din;
    logic [W-1:0]  crc_n;

    // Accepting a word applies its top bit at once; 15 steps remain.
    assign cin = acc_i ? base : crc_q;
    assign din = acc_i ? data_i[DW-1] : sh_q[DW-1];

    crc8si_unroll #(.W(W), .STEPS(1), .POLY(POLY)) u_unroll (
      .c_in (cin),
      .d_in (din),
      .c_out(upd)
    );

    always_comb begin
      sh_nxt  = sh_q;
      cnt_nxt = cnt_q;
      bsy_nxt = bsy_q;
      crc_n   = crc_q;
      if (acc_i) begin
        crc_n   = upd;
        sh_nxt  = {data_i[DW-2:0], 1'b0};
        cnt_nxt = '0;
        bsy_nxt = 1'b1;
      end else if (start_i) begin
        crc_n   = SEED;
        bsy_nxt = 1'b0;
      end else if (bsy_q) begin
        crc_n   = upd;
        sh_nxt  = {sh_q[DW-2:0], 1'b0};
        cnt_nxt = cnt_q + 1'b1;
        bsy_nxt = (cnt_q != LAST);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q  <= '0;
        cnt_q <= '0;
        bsy_q <= 1'b0;
      end else begin
        sh_q  <= sh_nxt;
        cnt_q <= cnt_nxt;
        bsy_q <= bsy_nxt;
      end
    end

    assign crc_nxt_o  = crc_n;
    assign busy_q_o   = bsy_q;
    assign busy_nxt_o = bsy_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= SEED;
    else        crc_q <= crc_nxt_o;
  end
endmodule

// File: rtl/crc8si_finish.sv
// End-request handling: deferral, done pulse, inverted result register.
module crc8si_finish #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         end_i,
  input  logic         busy_nxt_i,
  input  logic [W-1:0] crc_nxt_i,
  output logic         pend_o,
  output logic [W-1:0] res_o,
  output logic         done_o
);
  logic take;

  assign take = (end_i | pend_o) & ~start_i & ~busy_nxt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
      res_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        pend_o <= 1'b0;
        res_o  <= '0;
      end else if (take) begin
        res_o  <= ~crc_nxt_i;
        done_o <= 1'b1;
        pend_o <= 1'b0;
      end else if (end_i) begin
        pend_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/crc8_seed_inv.sv
module crc8_seed_inv
  import crc8si_pkg::*;
#(
  parameter feed_mode_e   MODE   = FEED_WORD,
  parameter int unsigned  CRC_W  = 8,
  parameter int unsigned  WORD_W = 16,
  parameter logic [CRC_W-1:0] POLY = 8'h1D,
  parameter logic [CRC_W-1:0] SEED = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start_i,
  input  logic              wd_valid_i,
  output logic              wd_ready_o,
  input  logic [WORD_W-1:0] wd_data_i,
  input  logic              xfer_end_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              crc_done_o
);
  logic             acc;
  logic             busy_q, busy_nxt, pend;
  logic [CRC_W-1:0] crc_nxt;

  assign wd_ready_o = ~busy_q & ~pend;
  assign acc        = wd_valid_i & wd_ready_o;

  crc8si_feed #(
    .MODE(MODE), .W(CRC_W), .DW(WORD_W), .POLY(POLY), .SEED(SEED)
  ) u_feed (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (xfer_start_i),
    .acc_i     (acc),
    .data_i    (wd_data_i),
    .crc_nxt_o (crc_nxt),
    .busy_q_o  (busy_q),
    .busy_nxt_o(busy_nxt)
  );

  crc8si_finish #(.W(CRC_W)) u_finish (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (xfer_start_i),
    .end_i     (xfer_end_i),
    .busy_nxt_i(busy_nxt),
    .crc_nxt_i (crc_nxt),
    .pend_o    (pend),
    .res_o     (crc_o),
    .done_o    (crc_done_o)
  );
endmodule

// File: rtl/crc8si_chk.sv
module crc8si_chk
  import crc8si_pkg::*;
#(
  parameter feed_mode_e  MODE  = FEED_WORD,
  parameter int unsigned CRC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xfer_start_i,
  input logic             wd_valid_i,
  input logic             wd_ready_o,
  input logic             xfer_end_i,
  input logic [CRC_W-1:0] crc_o,
  input logic             crc_done_o
);
  // R6: result only moves on a done pulse or after a start
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_start_i |=> ($stable(crc_o) || crc_done_o));

  // R7: start clears the result and suppresses done
  p_start_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start_i |=> (crc_o == '0 && !crc_done_o));

  // R7: no done pulse directly after a start
  p_no_done_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    crc_done_o |-> !$past(xfer_start_i));

  if (MODE == FEED_WORD) begin : g_word_chk
    // R3: end request answered on the next cycle
    p_done_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_end_i && !xfer_start_i) |=> crc_done_o);
  end else begin : g_bit_chk
    // R4: an accepted word closes the input while shifting
    p_busy_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_valid_i && wd_ready_o) |=> !wd_ready_o);
  end
endmodule

bind crc8_seed_inv crc8si_chk #(.MODE(MODE), .CRC_W(CRC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .xfer_start_i(xfer_start_i),
  .wd_valid_i  (wd_valid_i),
  .wd_ready_o  (wd_ready_o),
  .xfer_end_i  (xfer_end_i),
  .crc_o       (crc_o),
  .crc_done_o  (crc_done_o)
);

// File: tb/crc8_seed_inv_tb_top.sv
module crc8_seed_inv_tb_top;
  import crc8si_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        p_start = 0, p_valid = 0, p_end = 0, p_ready, p_done;
  logic [15:0] p_data = '0;
  logic [7:0]  p_crc;
  logic        s_start = 0, s_valid = 0, s_end = 0, s_ready, s_done;
  logic [15:0] s_data = '0;
  logic [7:0]  s_crc;

  crc8_seed_inv #(.MODE(FEED_WORD)) dut_i (
    .clk(clk), .rst_n(rst_n), .xfer_start_i(p_start), .wd_valid_i(p_valid),
    .wd_ready_o(p_ready), .wd_data_i(p_data), .xfer_end_i(p_end),
    .crc_o(p_crc), .crc_done_o(p_done));

  crc8_seed_inv #(.MODE(FEED_BIT)) dut_s_i (
    .clk(clk), .rst_n(rst_n), .xfer_start_i(s_start), .wd_valid_i(s_valid),
    .wd_ready_o(s_ready), .wd_data_i(s_data), .xfer_end_i(s_end),
    .crc_o(s_crc), .crc_done_o(s_done));

  int checks = 0, failures = 0;
  logic [15:0] wq [8];

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input int n);
    logic [7:0] c = 8'hFF;
    for (int k = 0; k < n; k++)
      for (int b = 15; b >= 0; b--) begin
        logic fb = c[7] ^ wq[k][b];
        c = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
      end
    return ~c;
  endfunction

  // word engine: first word rides with the start pulse (R2)
  task automatic p_xfer(input int n, input logic [7:0] exp, input string req);
    @(negedge clk); p_start = 1; p_valid = (n > 0); p_data = wq[0];
    for (int i = 1; i < n; i++) begin
      @(negedge clk); chk({req, " R3 ready"}, p_ready, 1);
      p_start = 0; p_valid = 1; p_data = wq[i];
    end
    @(negedge clk); p_start = 0; p_valid = 0; p_end = 1;
    @(negedge clk); p_end = 0;
    chk({req, " R3 done"}, p_done, 1);
    chk({req, " crc"}, p_crc, exp);
    @(negedge clk);
    chk({req, " R6 pulse"}, p_done, 0);
    chk({req, " R6 held"}, p_crc, exp);
  endtask

  // bit engine: end raised while the last word shifts (R5)
  task automatic s_xfer(input int n, input logic [7:0] exp, input string req);
    int cnt;
    @(negedge clk); s_start = 1;
    @(negedge clk); s_start = 0;
    for (int i = 0; i < n; i++) begin
      s_valid = 1; s_data = wq[i];
      while (!s_ready) @(negedge clk);
      @(negedge clk); s_valid = 0;
      if (i < n - 1) begin
        cnt = 0;
        while (!s_ready && cnt < 40) begin cnt++; @(negedge clk); end
        chk({req, " R4 ready low"}, 16'(cnt), 16'd15);
      end
    end
    s_end = 1;
    cnt = 0;
    do begin @(negedge clk); s_end = 0; cnt++; end while (!s_done && cnt < 40);
    chk({req, " R5 done delay"}, 16'(cnt), (n > 0) ? 16'd15 : 16'd1);
    chk({req, " R4 crc"}, s_crc, exp);
    @(negedge clk);
    chk({req, " R6 pulse"}, s_done, 0);
  endtask

  task automatic t_reset();
    chk("R9 crc", p_crc, 0);   chk("R9 done", p_done, 0); chk("R9 ready", p_ready, 1);
    chk("R9 crc s", s_crc, 0); chk("R9 done s", s_done, 0); chk("R9 ready s", s_ready, 1);
  endtask

  task automatic t_known();
    wq[0] = 16'h5081; wq[1] = 16'h0804;
    p_xfer(2, 8'h89, "R1 word");
    s_xfer(2, 8'h89, "R1 bit");
  endtask

  task automatic t_empty();
    p_xfer(0, 8'h00, "R8 word");
    s_xfer(0, 8'h00, "R8 bit");
  endtask

  task automatic t_abort();
    // word engine: partial transfer then a fresh one
    @(negedge clk); p_start = 1; p_valid = 1; p_data = 16'hDEAD;
    @(negedge clk); p_start = 0; p_data = 16'hBEEF;
    @(negedge clk); p_valid = 0;
    wq[0] = 16'h1234; wq[1] = 16'hA5C3;
    p_xfer(2, ref_crc(2), "R2 word");
    // bit engine: start lands mid-word
    @(negedge clk); s_start = 1;
    @(negedge clk); s_start = 0; s_valid = 1; s_data = 16'hFFFF;
    @(negedge clk); s_valid = 0;
    repeat (3) @(negedge clk);
    chk("R2 busy before abort", s_ready, 0);
    wq[0] = 16'h0F0F; wq[1] = 16'h8001; wq[2] = 16'h7777;
    s_xfer(3, ref_crc(3), "R2 bit");
  endtask

  task automatic t_start_end_same();
    wq[0] = 16'h4242;
    p_xfer(1, ref_crc(1), "R7 pre");
    @(negedge clk); p_start = 1; p_end = 1;
    @(negedge clk); p_start = 0; p_end = 0;
    chk("R7 no done", p_done, 0);
    chk("R7 cleared", p_crc, 0);
    @(negedge clk);
    chk("R7 still no done", p_done, 0);
  endtask

  task automatic t_hold();
    logic [7:0] e;
    wq[0] = 16'hC001; wq[1] = 16'h00FF;
    e = ref_crc(2);
    p_xfer(2, e, "R6 pre");
    @(negedge clk); p_valid = 1; p_data = 16'h5555;
    @(negedge clk); p_valid = 0;
    repeat (3) @(negedge clk);
    chk("R6 held after extra word", p_crc, e);
    chk("R6 no done", p_done, 0);
  endtask

  task automatic t_random();
    for (int it = 0; it < 20; it++) begin
      int n = 1 + int'($urandom_range(5));
      for (int k = 0; k < n; k++) wq[k] = 16'($urandom);
      p_xfer(n, ref_crc(n), "R1 rnd word");
      s_xfer(n, ref_crc(n), "R4 rnd bit");
    end
  endtask

  bit finished = 0;
  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_known();
    t_empty();
    t_abort();
    t_start_end_same();
    t_hold();
    t_random();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule